// File: doc/BRIEF.md
# Packed Multiply-Add and Sign Unit

This block is a 128-bit packed integer datapath stage that performs one of three lane-wise operations on two operand vectors, A and B, and returns the result one clock later. The first operation multiplies each byte of A, read as unsigned, by the byte of B at the same position, read as signed. It then adds each pair of neighbouring products into a signed 16-bit lane and clamps that lane at the 16-bit signed limits. The second operation is a signed 16-bit fixed-point multiply that keeps the rounded high half of a scaled product. The third operation copies, negates or clears each element of A according to the sign of the matching element of B, with an element width of 8, 16 or 32 bits.

A request is a single-cycle strobe with both operands, an operation code and an element-size code. The result register loads on the clock edge where the strobe is high. The result valid flag is high in the cycle that follows. The register keeps its value while no request arrives. All lanes are little-endian: byte i occupies bits 8i+7:8i, and 16-bit lane k occupies bits 16k+15:16k.

Top module: `pmas_unit`

## Requirements
- R1: With op code 00, result lane k equals ua(2k)*sb(2k) + ua(2k+1)*sb(2k+1). Here ua(i) is byte i of A taken as unsigned 0..255, and sb(i) is byte i of B taken as signed -128..127.
- R2: In op 00, a pair sum above 32767 yields 0x7FFF, and a pair sum below -32768 yields 0x8000.
- R3: With op code 01, each 16-bit lane forms the signed product p = a*b and computes t = (p >>> 14) + 1. Bits 16:1 of t become the lane result. Examples: 5*32767 gives 5, 7*-32768 gives -7, 2*128 gives 0, and -32768*-32768 gives 0x8000.
- R4: With op code 10, an element of A whose matching B element is negative is replaced by its two's complement negation.
- R5: With op code 10, an element is cleared to zero when its B element is zero and passed unchanged when its B element is positive.
- R6: With op code 10, size code 00 selects 8-bit elements, 01 selects 16-bit elements, and 10 or 11 selects 32-bit elements. Ops 00 and 01 ignore the size code.
- R7: Negating the most negative element value returns that same value (for example 0x80 or 0x8000).
- R8: Op code 11 produces an all-zero result.
- R9: out_valid is high exactly in the cycle after a cycle with in_valid high, and out_data holds that request's result in that cycle.
- R10: While in_valid is low, operand and code changes have no effect and out_data keeps its value.
- R11: A synchronous active-high reset clears out_valid and out_data to zero on the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request strobe, one cycle per request |
| op_sel | input | 2 | Operation: 00 multiply-add, 01 rounded multiply, 10 sign, 11 zero |
| elem_sz | input | 2 | Sign-mode element width: 00 byte, 01 half, 10/11 word |
| opa | input | 128 | Operand A |
| opb | input | 128 | Operand B |
| out_valid | output | 1 | Result valid, one cycle after the request |
| out_data | output | 128 | Registered result |

## Verification
The properties assume that the request inputs carry known values on every clock edge. They also assume that reset is sampled synchronously, so every timing relation is measured from the first edge with reset low. The zero-result properties depend on one whole operand being zero for a given op code. The bench therefore issues some requests with an all-zero A or B, and it changes inputs only on the falling clock edge. Each request pulses the strobe for one cycle, so the latency and hold relations are checked against single, isolated requests. The idle cycles between requests exercise the hold rule while the bench alters the operand buses.

// File: rtl/pmas_pkg.sv
package pmas_pkg;

    localparam int BYTE_W = 8;
    localparam int HALF_W = 16;
    localparam int WORD_W = 32;

    typedef enum logic [1:0] {
        OP_MADD  = 2'b00,
        OP_MULHR = 2'b01,
        OP_SIGN  = 2'b10,
        OP_NONE  = 2'b11
    } op_e;

    typedef enum logic [1:0] {
        SZ_BYTE  = 2'b00,
        SZ_HALF  = 2'b01,
        SZ_WORD  = 2'b10,
        SZ_WORD2 = 2'b11
    } esz_e;

    typedef struct packed {
        op_e  op;
        esz_e sz;
    } ctl_t;

    // Clamp an 18-bit signed pair sum into a signed 16-bit lane.
    function automatic logic [15:0] sat_s16(input logic signed [17:0] v);
        if (v > 18'sd32767)
            return 16'h7FFF;
        else if (v < -18'sd32768)
            return 16'h8000;
        else
            return v[15:0];
    endfunction

endpackage

// File: rtl/pmas_madd.sv
module pmas_madd
    import pmas_pkg::*;
#(
    parameter int VEC_W = 128
) (
    input  logic [VEC_W-1:0] a_i,
    input  logic [VEC_W-1:0] b_i,
    output logic [VEC_W-1:0] y_o
);
    localparam int LANES = VEC_W / HALF_W;

    for (genvar k = 0; k < LANES; k++) begin : g_lane
        logic signed [8:0]  ua_lo, ua_hi;
        logic signed [7:0]  sb_lo, sb_hi;
        logic signed [16:0] prod_lo, prod_hi;
        logic signed [17:0] pair_sum;

        // A bytes are zero-extended so they stay unsigned inside a signed multiply.
        assign ua_lo = $signed({1'b0, a_i[HALF_W*k +: BYTE_W]});
        assign ua_hi = $signed({1'b0, a_i[HALF_W*k+BYTE_W +: BYTE_W]});
        assign sb_lo = $signed(b_i[HALF_W*k +: BYTE_W]);
        assign sb_hi = $signed(b_i[HALF_W*k+BYTE_W +: BYTE_W]);

        assign prod_lo  = 17'(ua_lo) * 17'(sb_lo);
        assign prod_hi  = 17'(ua_hi) * 17'(sb_hi);
        assign pair_sum = 18'(prod_lo) + 18'(prod_hi);

        assign y_o[HALF_W*k +: HALF_W] = sat_s16(pair_sum);
    end

endmodule

// File: rtl/pmas_mulhr.sv
module pmas_mulhr
    import pmas_pkg::*;
#(
    parameter int VEC_W = 128
) (
    input  logic [VEC_W-1:0] a_i,
    input  logic [VEC_W-1:0] b_i,
    output logic [VEC_W-1:0] y_o
);
    localparam int LANES  = VEC_W / HALF_W;
    localparam int PROD_W = 2 * HALF_W;
    localparam int KEEP_W = 18;
    localparam int SHIFT  = PROD_W - KEEP_W;

    for (genvar k = 0; k < LANES; k++) begin : g_lane
        logic signed [PROD_W-1:0] prod;
        logic signed [KEEP_W-1:0] scaled;
        logic        [KEEP_W-1:0] rounded;
        logic                     unused_bits;

        assign prod    = PROD_W'($signed(a_i[HALF_W*k +: HALF_W]))
                       * PROD_W'($signed(b_i[HALF_W*k +: HALF_W]));
        // Arithmetic shift right by 14 keeps the top 18 bits of the product.
        assign scaled  = prod[PROD_W-1 -: KEEP_W];
        assign rounded = scaled + KEEP_W'(1);
        assign y_o[HALF_W*k +: HALF_W] = rounded[HALF_W:1];

        assign unused_bits = ^{prod[SHIFT-1:0], rounded[KEEP_W-1], rounded[0]};
    end

endmodule

// File: rtl/pmas_sign_elem.sv
module pmas_sign_elem #(
    parameter int EW = 8
) (
    input  logic [EW-1:0] x_i,
    input  logic [EW-1:0] s_i,
    output logic [EW-1:0] y_o
);
    always_comb begin
        if (s_i[EW-1])
            y_o = '0 - x_i;          // wraps on the most negative value
        else if (s_i == '0)
            y_o = '0;
        else
            y_o = x_i;
    end
endmodule

// File: rtl/pmas_sign.sv
module pmas_sign
    import pmas_pkg::*;
#(
    parameter int VEC_W = 128
) (
    input  logic [VEC_W-1:0] a_i,
    input  logic [VEC_W-1:0] b_i,
    input  esz_e             sz_i,
    output logic [VEC_W-1:0] y_o
);
    localparam int NWIDTH = 3;

    logic [NWIDTH-1:0][VEC_W-1:0] by_width;

    for (genvar w = 0; w < NWIDTH; w++) begin : g_width
        localparam int EW = BYTE_W << w;
        localparam int NE = VEC_W / EW;
        for (genvar e = 0; e < NE; e++) begin : g_elem
            pmas_sign_elem #(.EW(EW)) u_elem (
                .x_i (a_i[e*EW +: EW]),
                .s_i (b_i[e*EW +: EW]),
                .y_o (by_width[w][e*EW +: EW])
            );
        end
    end

    always_comb begin
        case (sz_i)
            SZ_BYTE: y_o = by_width[0];
            SZ_HALF: y_o = by_width[1];
            default: y_o = by_width[2];
        endcase
    end

endmodule

// File: rtl/pmas_unit.sv
module pmas_unit
    import pmas_pkg::*;
#(
    parameter int VEC_W = 128
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    input  logic [1:0]       op_sel,
    input  logic [1:0]       elem_sz,
    input  logic [VEC_W-1:0] opa,
    input  logic [VEC_W-1:0] opb,
    output logic             out_valid,
    output logic [VEC_W-1:0] out_data
);
    ctl_t             ctl;
    logic [VEC_W-1:0] madd_res;
    logic [VEC_W-1:0] mulhr_res;
    logic [VEC_W-1:0] sign_res;
    logic [VEC_W-1:0] next_res;

    assign ctl.op = op_e'(op_sel);
    assign ctl.sz = esz_e'(elem_sz);

    pmas_madd #(.VEC_W(VEC_W)) u_madd (
        .a_i (opa),
        .b_i (opb),
        .y_o (madd_res)
    );

    pmas_mulhr #(.VEC_W(VEC_W)) u_mulhr (
        .a_i (opa),
        .b_i (opb),
        .y_o (mulhr_res)
    );

    pmas_sign #(.VEC_W(VEC_W)) u_sign (
        .a_i  (opa),
        .b_i  (opb),
        .sz_i (ctl.sz),
        .y_o  (sign_res)
    );

    always_comb begin
        case (ctl.op)
            OP_MADD:  next_res = madd_res;
            OP_MULHR: next_res = mulhr_res;
            OP_SIGN:  next_res = sign_res;
            default:  next_res = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_data  <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid)
                out_data <= next_res;
        end
    end

    // R9: result valid follows a request by exactly one cycle
    p_valid_lat_r9: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);
    p_idle_r9: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);
    // R10: no request, no change to the result
    p_hold_r10: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> $stable(out_data));
    // R11: reset clears the outputs
    p_reset_r11: assert property (@(posedge clk)
        rst |=> (!out_valid && out_data == '0));
    // R8: unused op code gives zero
    p_op_none_r8: assert property (@(posedge clk) disable iff (rst)
        (in_valid && op_sel == 2'b11) |=> out_data == '0);
    // R5: all-zero B in sign mode clears every element
    p_sign_zero_r5: assert property (@(posedge clk) disable iff (rst)
        (in_valid && op_sel == 2'b10 && opb == '0) |=> out_data == '0);
    // R1: all-zero A gives zero pair sums
    p_madd_zero_r1: assert property (@(posedge clk) disable iff (rst)
        (in_valid && op_sel == 2'b00 && opa == '0) |=> out_data == '0);
    // R3: zero product rounds to zero
    p_mulhr_zero_r3: assert property (@(posedge clk) disable iff (rst)
        (in_valid && op_sel == 2'b01 && opb == '0) |=> out_data == '0);

endmodule

// File: tb/pmas_unit_tb.sv
module pmas_unit_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 5000;
    localparam int NV         = 20;

    typedef struct packed {
        logic [3:0]   req;
        logic [1:0]   op;
        logic [1:0]   sz;
        logic [127:0] a;
        logic [127:0] b;
        logic [127:0] exp;
    } vec_t;

    // Tags: entries 0-2 R1, 3-4 R2, 5-8 R3, 9 R4, 10-11 R5, 12-15 and 19 R6, 16-17 R7, 18 R8
    localparam vec_t VT [NV] = '{
        '{4'd1, 2'd0, 2'd0, {16{8'h02}}, {16{8'h03}}, {8{16'h000C}}},
        '{4'd1, 2'd0, 2'd0, {8{16'h0201}}, {8{16'h3F04}}, {8{16'h0082}}},
        '{4'd1, 2'd0, 2'd0, {16{8'hFF}}, {16{8'h01}}, {8{16'h01FE}}},
        '{4'd2, 2'd0, 2'd0, {16{8'hFF}}, {16{8'h7F}}, {8{16'h7FFF}}},
        '{4'd2, 2'd0, 2'd0, {16{8'hFF}}, {16{8'h80}}, {8{16'h8000}}},
        '{4'd3, 2'd1, 2'd0, {8{16'h0005}}, {8{16'h7FFF}}, {8{16'h0005}}},
        '{4'd3, 2'd1, 2'd0, {8{16'h0007}}, {8{16'h8000}}, {8{16'hFFF9}}},
        '{4'd3, 2'd1, 2'd0, {8{16'h0002}}, {8{16'h0080}}, {8{16'h0000}}},
        '{4'd3, 2'd1, 2'd0, {8{16'h8000}}, {8{16'h8000}}, {8{16'h8000}}},
        '{4'd4, 2'd2, 2'd0, {16{8'h05}}, {16{8'hFF}}, {16{8'hFB}}},
        '{4'd5, 2'd2, 2'd1, {8{16'h1234}}, {8{16'h0001}}, {8{16'h1234}}},
        '{4'd5, 2'd2, 2'd2, {4{32'hDEADBEEF}}, 128'h0, 128'h0},
        '{4'd6, 2'd2, 2'd0, {8{16'h0102}}, {8{16'hFF00}}, {8{16'hFF00}}},
        '{4'd6, 2'd2, 2'd1, {8{16'h0102}}, {8{16'hFF00}}, {8{16'hFEFE}}},
        '{4'd6, 2'd2, 2'd2, {8{16'h0102}}, {8{16'hFF00}}, {4{32'hFEFDFEFE}}},
        '{4'd6, 2'd2, 2'd3, {8{16'h0102}}, {8{16'hFF00}}, {4{32'hFEFDFEFE}}},
        '{4'd7, 2'd2, 2'd0, {16{8'h80}}, {16{8'h80}}, {16{8'h80}}},
        '{4'd7, 2'd2, 2'd1, {8{16'h8000}}, {8{16'hFFFF}}, {8{16'h8000}}},
        '{4'd8, 2'd3, 2'd0, {16{8'h5A}}, {16{8'h33}}, 128'h0},
        '{4'd6, 2'd0, 2'd2, {8{16'h0201}}, {8{16'h3F04}}, {8{16'h0082}}}
    };

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         in_valid = 1'b0;
    logic [1:0]   op_sel = 2'd0;
    logic [1:0]   elem_sz = 2'd0;
    logic [127:0] opa = '0;
    logic [127:0] opb = '0;
    logic         out_valid;
    logic [127:0] out_data;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;
    longint unsigned lcg = 64'h1234_5678_9ABC_DEF1;

    always #(CLK_PERIOD/2) clk = ~clk;

    pmas_unit dut_i (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .op_sel    (op_sel),
        .elem_sz   (elem_sz),
        .opa       (opa),
        .opb       (opb),
        .out_valid (out_valid),
        .out_data  (out_data)
    );

    // ---------------- reference models ----------------
    function automatic logic [127:0] m_madd(input logic [127:0] a, input logic [127:0] b);
        logic [127:0] r = '0;
        for (int k = 0; k < 8; k++) begin
            int u0 = int'(a[16*k +: 8]);
            int u1 = int'(a[16*k+8 +: 8]);
            int s0 = int'($signed(b[16*k +: 8]));
            int s1 = int'($signed(b[16*k+8 +: 8]));
            int s  = u0 * s0 + u1 * s1;
            if (s > 32767) s = 32767;
            if (s < -32768) s = -32768;
            r[16*k +: 16] = s[15:0];
        end
        return r;
    endfunction

    function automatic logic [127:0] m_mulhr(input logic [127:0] a, input logic [127:0] b);
        logic [127:0] r = '0;
        for (int k = 0; k < 8; k++) begin
            int p = int'($signed(a[16*k +: 16])) * int'($signed(b[16*k +: 16]));
            int t = (p >>> 14) + 1;
            r[16*k +: 16] = t[16:1];
        end
        return r;
    endfunction

    function automatic logic [127:0] m_sign(input logic [127:0] a, input logic [127:0] b, input int w);
        logic [127:0] r = '0;
        logic [31:0] mask = (w == 32) ? 32'hFFFF_FFFF : ((32'h1 << w) - 32'h1);
        for (int e = 0; e < 128 / w; e++) begin
            logic [31:0] xa = 32'(a >> (e * w)) & mask;
            logic [31:0] xb = 32'(b >> (e * w)) & mask;
            logic [31:0] res;
            if (xb[w-1])       res = (32'h0 - xa) & mask;
            else if (xb == 0)  res = 32'h0;
            else               res = xa;
            r = r | (128'(res) << (e * w));
        end
        return r;
    endfunction

    function automatic logic [127:0] m_any(input logic [1:0] op, input logic [1:0] sz,
                                           input logic [127:0] a, input logic [127:0] b);
        case (op)
            2'd0: return m_madd(a, b);
            2'd1: return m_mulhr(a, b);
            2'd2: return m_sign(a, b, (sz == 2'd0) ? 8 : (sz == 2'd1) ? 16 : 32);
            default: return '0;
        endcase
    endfunction

    function automatic logic [31:0] draw32();
        lcg = lcg * 64'd6364136223846793005 + 64'd1442695040888963407;
        return lcg[63:32];
    endfunction

    // ---------------- check helpers ----------------
    task automatic chk128(input string tag, input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic chk1(input string tag, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%b expected=%b", tag, act, exp);
        end
    endtask

    // One request; returns at the falling edge where the result is visible.
    task automatic apply(input logic [1:0] op, input logic [1:0] sz,
                         input logic [127:0] a, input logic [127:0] b);
        @(negedge clk);
        in_valid = 1'b1;
        op_sel   = op;
        elem_sz  = sz;
        opa      = a;
        opb      = b;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    // ---------------- main sequence ----------------
    initial begin
        logic [127:0] held;
        repeat (3) @(negedge clk);
        // R11: reset state
        chk1("R11 reset out_valid", out_valid, 1'b0);
        chk128("R11 reset out_data", out_data, '0);
        rst = 1'b0;

        // table walk
        for (int i = 0; i < NV; i++) begin
            apply(VT[i].op, VT[i].sz, VT[i].a, VT[i].b);
            checks++;
            if (out_data !== VT[i].exp) begin
                failures++;
                $display("FAIL R%0d table entry %0d actual=%h expected=%h",
                         VT[i].req, i, out_data, VT[i].exp);
            end
        end

        // R9: valid for exactly one cycle, data in that cycle
        apply(2'd0, 2'd0, {8{16'h0201}}, {8{16'h3F04}});
        chk1("R9 out_valid after request", out_valid, 1'b1);
        chk128("R9 data with valid", out_data, {8{16'h0082}});
        @(negedge clk);
        chk1("R9 out_valid drops", out_valid, 1'b0);

        // R10: bus activity without strobe is ignored
        held = out_data;
        op_sel  = 2'd2;
        elem_sz = 2'd0;
        opa     = {16{8'h11}};
        opb     = {16{8'hFF}};
        repeat (3) @(negedge clk);
        chk128("R10 result held", out_data, held);
        chk1("R10 no valid", out_valid, 1'b0);

        // model-based mixed patterns covering R1 R3 R4 R5 R6
        for (int n = 0; n < 40; n++) begin
            logic [127:0] a = {draw32(), draw32(), draw32(), draw32()};
            logic [127:0] b = {draw32(), draw32(), draw32(), draw32()};
            logic [1:0] op = 2'(n % 3);
            logic [1:0] sz = 2'((n / 3) % 4);
            if (n % 7 == 0) b[31:0] = '0;   // zero elements for R5
            apply(op, sz, a, b);
            chk128((op == 2'd0) ? "R1 mixed" : (op == 2'd1) ? "R3 mixed" : "R4 R5 R6 mixed",
                   out_data, m_any(op, sz, a, b));
        end

        // R11: mid-run reset clears a nonzero result
        apply(2'd2, 2'd0, {16{8'h05}}, {16{8'h01}});
        chk128("R11 pre-reset nonzero", out_data, {16{8'h05}});
        rst = 1'b1;
        @(negedge clk);
        chk128("R11 reset clears data", out_data, '0);
        chk1("R11 reset clears valid", out_valid, 1'b0);
        rst = 1'b0;
        @(negedge clk);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL R9 watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule